// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block turns its input clock into a slower periodic signal whose period comes from a small divisor field. It produces two outputs in the source clock domain. The first is a registered divided level, high for the first half of every period. The second is a one-cycle tick in the last cycle of every period. An enable bit gates both outputs. Software loads the divisor field and the enable bit through a simple write port. It reads back the divisor in force, the enable bit and a busy flag through a combinational read port.

A new divisor never cuts a period short. The block keeps it pending until the period in progress ends, and a status flag stays busy until then. A second write that arrives while busy is queued behind the first, so both values take effect in order. Enable changes also wait for the end of a period. When a change lands, the divided level is low and no partial pulse can appear. A parameter picks the field format: a 5-bit field, or a 6-bit field whose top bit multiplies the low five bits by 64.

Top module: `clkdiv_top`

## Requirements
- R1: In 5-bit format (EXT_MODE=0), a field value N from 1 to 31 gives a period of N input cycles. Write-data bits above bit 4 are ignored.
- R2: A field value of 0 gives the largest period: 32 cycles in 5-bit format and 64 cycles in 6-bit format.
- R3: In 6-bit format (EXT_MODE=1), when field bit 5 is set the period is 64 times bits 4..0. Field 0x20 gives 64. When bit 5 is clear the period equals bits 4..0.
- R4: When the enable bit (address 1, data bit 0) is 0 and has taken effect, `tick_o` and `clk_o` stay low. Setting it to 1 resumes ticks at the programmed period.
- R5: A read of address 1 returns the enable bit last written, in bit 0, from the cycle after the write.
- R6: A read of address 2 returns 0x18 (bits 3 and 4 set) while a divisor update is pending, and 0x00 otherwise. Busy rises in the cycle after a write to address 0.
- R7: A divisor written during a period takes effect only after that period completes with the old divisor.
- R8: An enable change takes effect only at a period boundary. Every high phase of `clk_o` therefore has the full length given by R11.
- R9: A divisor written while busy is held. It takes effect at the boundary after the pending one is applied, and busy stays set until both are applied.
- R10: After reset, both outputs are low, the enable bit reads 0, status reads 0x00 and the field reads 0.
- R11: `clk_o` is high for the first ceil(N/2) cycles of each N-cycle period. `tick_o` is high for exactly the last cycle of each period.
- R12: A read of address 0 returns the field currently in force, not a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 divisor field, 1 enable bit |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 0 field, 1 enable, 2 status |
| rd_data | output | DATA_W | Read data, combinational |
| clk_o | output | 1 | Divided level, registered |
| tick_o | output | 1 | One-cycle pulse in the last cycle of each period |

## Verification
On every cycle, the in-line assertions check four things. Field and enable changes happen only at a period boundary. The counter stays inside the current period. Both outputs are silent while the block is gated. A queued write always implies busy. Only the bench scenarios can show the actual period lengths and high-phase widths for each field value, including the zero and 64x encodings. They also show that an update issued mid-period leaves that period at its old length, and that two back-to-back writes produce the old, first and second periods in sequence.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam logic [1:0] ADDR_DIV  = 2'd0;
    localparam logic [1:0] ADDR_GATE = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // period length in input cycles for a field value
    function automatic logic [10:0] eff_div(input logic [5:0] f, input logic ext);
        logic [10:0] v;
        if (ext) begin
            v = f[5] ? {f[4:0], 6'b0} : {6'b0, f[4:0]};
            if (v == '0) v = 11'd64;
        end else begin
            v = {6'b0, f[4:0]};
            if (v == '0) v = 11'd32;
        end
        return v;
    endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [1:0]         rd_addr,
    input  logic               wrap,
    output logic [DATA_W-1:0]  rd_data,
    output logic [FIELD_W-1:0] field_now,
    output logic [FIELD_W-1:0] field_next,
    output logic               gate_req
);
    typedef struct packed {
        logic [FIELD_W-1:0] active;
        logic [FIELD_W-1:0] nxt;
        logic [FIELD_W-1:0] hold;
        logic               busy;
        logic               hold_v;
        logic               gate_req;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wrap && q.busy) begin
            d.active = q.nxt;
            if (q.hold_v) begin
                d.nxt    = q.hold;
                d.hold_v = 1'b0;
            end else begin
                d.busy = 1'b0;
            end
        end
        if (wr_en && wr_addr == ADDR_DIV) begin
            if (d.busy) begin
                d.hold   = wr_data[FIELD_W-1:0];
                d.hold_v = 1'b1;
            end else begin
                d.nxt  = wr_data[FIELD_W-1:0];
                d.busy = 1'b1;
            end
        end
        if (wr_en && wr_addr == ADDR_GATE) d.gate_req = wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_DIV:  rd_data[FIELD_W-1:0] = q.active;
            ADDR_GATE: rd_data[0] = q.gate_req;
            ADDR_STAT: begin
                rd_data[3] = q.busy;
                rd_data[4] = q.busy;
            end
            default:   rd_data = '0;
        endcase
    end

    assign field_now  = q.active;
    assign field_next = d.active;
    assign gate_req   = q.gate_req;

    assert_field_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.active) |-> $past(wrap));
    assert_busy_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DIV) |=> q.busy);
    assert_busy_ends_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(wrap));
    assert_queue_keeps_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold_v |-> q.busy);
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int CNT_W   = 6,
    parameter bit EXT     = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] field_now,
    input  logic [FIELD_W-1:0] field_next,
    input  logic               gate_req,
    output logic               wrap,
    output logic               clk_o,
    output logic               tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             gate;
        logic             lvl;
        logic             tick;
    } core_t;

    core_t q, d;
    logic [CNT_W-1:0] len_now, len_next;
    logic [CNT_W:0]   half_next;

    always_comb begin
        len_now   = CNT_W'(eff_div(6'(field_now), EXT));
        len_next  = CNT_W'(eff_div(6'(field_next), EXT));
        half_next = ({1'b0, len_next} + 1'b1) >> 1;
        wrap      = (q.cnt == len_now - 1'b1);
        d         = q;
        d.cnt     = wrap ? '0 : q.cnt + 1'b1;
        if (wrap) d.gate = gate_req;
        d.lvl     = d.gate && ({1'b0, d.cnt} < half_next);
        d.tick    = d.gate && (d.cnt == len_next - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign clk_o  = q.lvl;
    assign tick_o = q.tick;

    assert_count_in_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < len_now);
    assert_gate_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.gate) |-> q.cnt == '0);
    assert_quiet_when_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.gate |-> (!q.lvl && !q.tick));
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
    parameter bit EXT_MODE = 1'b0,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_o,
    output logic              tick_o
);
    localparam int FIELD_W = EXT_MODE ? 6 : 5;
    localparam int CNT_W   = EXT_MODE ? 11 : 6;

    logic [FIELD_W-1:0] field_now, field_next;
    logic               gate_req, wrap;

    clkdiv_regs #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .wrap(wrap), .rd_data(rd_data),
        .field_now(field_now), .field_next(field_next), .gate_req(gate_req)
    );

    clkdiv_core #(.FIELD_W(FIELD_W), .CNT_W(CNT_W), .EXT(EXT_MODE)) u_core (
        .clk(clk), .rst_n(rst_n), .field_now(field_now), .field_next(field_next),
        .gate_req(gate_req), .wrap(wrap), .clk_o(clk_o), .tick_o(tick_o)
    );
endmodule

// File: tb/clkdiv_top_test.sv
module clkdiv_top_test;
    localparam time CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data, rd_data_x;
    logic       clk_o, tick_o, clk_o_x, tick_o_x;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    int exp_q[$];
    int last_tick = 0;
    bit last_ok = 0;
    int hi_cnt = 0, allow_a = 0, allow_b = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clkdiv_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .clk_o(clk_o), .tick_o(tick_o)
    );
    clkdiv_top #(.EXT_MODE(1'b1)) uut_x (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_x), .clk_o(clk_o_x), .tick_o(tick_o_x)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: tick spacing against queued expectations
    always @(negedge clk) begin
        if (rst_n && tick_o) begin
            if (last_ok && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                check(cyc - last_tick == e, "R7/R9/R1 tick spacing", cyc - last_tick, e);
            end
            last_tick = cyc;
            last_ok = 1;
        end
    end

    // high-phase width monitor (R8, R11)
    always @(negedge clk) begin
        if (clk_o) hi_cnt++;
        else if (hi_cnt > 0) begin
            if (allow_a != 0)
                check(hi_cnt == allow_a || hi_cnt == allow_b, "R8/R11 high width", hi_cnt, allow_a);
            hi_cnt = 0;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        do rd(2'd2, v); while (v[3]);
    endtask

    task automatic sync_tick();
        @(negedge clk);
        while (!tick_o) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic run_div(input logic [7:0] f, input int exp, input int n, input int ha);
        wr(2'd0, f);
        wait_idle();
        allow_a = ha; allow_b = ha;
        sync_tick();
        for (int i = 0; i < n; i++) exp_q.push_back(exp);
        drain();
    endtask

    task automatic gap_x(input logic [7:0] f, input int exp, input string tag);
        int c;
        wr(2'd0, f);
        @(negedge clk);
        rd_addr = 2'd2;
        #1;
        while (rd_data_x[3]) begin @(negedge clk); #1; end
        while (!tick_o_x) @(negedge clk);
        c = 0;
        do begin @(negedge clk); c++; end while (!tick_o_x);
        check(c == exp, tag, c, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int tk, hi;
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        rd(2'd0, v); check(v == 8'h00, "R10 field after reset", v, 0);
        rd(2'd1, v); check(v == 8'h00, "R10 enable after reset", v, 0);
        rd(2'd2, v); check(v == 8'h00, "R10 status after reset", v, 0);
        check(!clk_o && !tick_o, "R10 outputs low", clk_o, 0);

        // R5 enable readback
        wr(2'd1, 8'h01);
        rd(2'd1, v); check(v == 8'h01, "R5 enable readback", v, 1);

        // R6 busy right after a write
        wr(2'd0, 8'd10);
        rd(2'd2, v); check(v == 8'h18, "R6 busy while pending", v, 8'h18);
        run_div(8'd10, 10, 3, 5);                 // R1, R11
        run_div(8'd7, 7, 2, 4);                   // R11 odd period
        run_div(8'd0, 32, 2, 16);                 // R2
        run_div(8'h25, 5, 2, 3);                  // R1 upper bits ignored
        rd(2'd0, v); check(v == 8'd5, "R12 field in force", v, 5);

        // R7: period in progress completes with old divisor
        allow_a = 3; allow_b = 4;
        sync_tick();
        exp_q.push_back(5); exp_q.push_back(8);
        wr(2'd0, 8'd8);
        drain();

        // R9: second write queued behind first
        allow_a = 0;
        sync_tick();
        exp_q.push_back(8); exp_q.push_back(7); exp_q.push_back(3); exp_q.push_back(3);
        wr(2'd0, 8'd7);
        wr(2'd0, 8'd3);
        rd(2'd2, v); check(v == 8'h18, "R9 busy while queued", v, 8'h18);
        rd(2'd0, v); check(v == 8'd8, "R12 pending not visible", v, 8);
        drain();
        rd(2'd2, v); check(v == 8'h00, "R9 busy cleared", v, 0);
        rd(2'd0, v); check(v == 8'd3, "R9 last write in force", v, 3);

        // R4, R8 gating
        run_div(8'd10, 10, 1, 5);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v == 8'h00, "R5 enable cleared", v, 0);
        repeat (25) @(negedge clk);
        tk = 0; hi = 0;
        repeat (30) begin @(negedge clk); tk += int'(tick_o); hi += int'(clk_o); end
        check(tk == 0, "R4 no ticks when gated", tk, 0);
        check(hi == 0, "R4 level low when gated", hi, 0);
        wr(2'd1, 8'h01);
        repeat (3) @(negedge clk);
        wr(2'd1, 8'h00);
        repeat (7) @(negedge clk);
        wr(2'd1, 8'h01);
        repeat (13) @(negedge clk);
        wr(2'd1, 8'h00);
        repeat (4) @(negedge clk);
        wr(2'd1, 8'h01);
        repeat (25) @(negedge clk);
        sync_tick();
        exp_q.push_back(10); exp_q.push_back(10);
        drain();

        // R1 divide by one: level stays high, tick every cycle
        run_div(8'd1, 1, 4, 0);
        check(clk_o == 1'b1, "R11 divide-by-one level", clk_o, 1);

        // R2, R3 six-bit format
        gap_x(8'h22, 128, "R3 64x predivide");
        gap_x(8'h20, 64, "R3 0x20 gives 64");
        gap_x(8'h00, 64, "R2 zero gives 64");
        gap_x(8'h05, 5, "R3 bit5 clear");

        finish_run();
    end
endmodule